// File: doc/BRIEF.md
# Raster Line Timing and Interrupt Generator

This block derives the vertical timing of a raster display from a free-running clock. Each clock adds a fixed step, in nanoseconds, to a remainder accumulator. Whenever the remainder covers one line period of the active video standard, the line counter advances and the period is subtracted. Any leftover time is kept, so the average line rate is exact even when the line period is not a whole number of clocks. When the line counter reaches the standard's total line count, it returns to zero, a retrace pulse fires and a retrace becomes pending.

Two compare values are loaded from a single packed write word. Each raises its own one-cycle scanline interrupt when the line counter lands on it. A pending retrace is turned into a frame-present strobe in one of two ways: when the counter advances onto a fixed presentation line, or immediately when software writes the display base address. The frame counter counts presentation strobes. The standard select is sampled at each frame wrap, and reset selects the 525-line standard.

The retrace tracker is a two-state machine. ST_SCAN means no retrace is pending, and ST_PENDING means a retrace is waiting to be presented. There are three transitions. ST_SCAN goes to ST_PENDING on a frame wrap. ST_PENDING goes to ST_SCAN on a presentation-line advance or on a base-address write. ST_PENDING stays in ST_PENDING when a base-address write coincides with a new wrap.

Top module: `raster_vtiming`

## Requirements
- R1: While reset is asserted and in the first cycle after it, line_o and frame_o read 0 and all pulse outputs are low. Reset selects the 525-line standard, clears both compare values to 0 and clears the pending retrace.
- R2: Every clock adds STEP_NS to a remainder. When the remainder reaches the active line period (31746 ns for the 525-line standard, 32000 ns for the 625-line standard), line_o rises by one in the next cycle and the period is subtracted, keeping the excess.
- R3: An advance from line total-1 sets line_o to 0, pulses retrace_o in that same cycle and makes a retrace pending (state ST_PENDING).
- R4: pal_sel_i is sampled only on a wrap. 1 selects 625 lines and 32000 ns, and 0 selects 525 lines and 31746 ns.
- R5: A cycle with cmp_wr_i high loads compare A from cmp_wdata_i[25:16] and compare B from cmp_wdata_i[9:0]. The new values take effect from the next cycle, and all other bits are ignored.
- R6: irq_a_o (irq_b_o) pulses in the cycle in which line_o first shows a value equal to compare A (B) after an advance, including 0 after a wrap. It never pulses without an advance.
- R7: With a retrace pending, an advance onto line PRESENT_LINE (default 65) pulses present_o in the cycle that line_o shows it, and clears the pending retrace.
- R8: base_wr_i high while a retrace is pending pulses present_o in the next cycle and clears the pending retrace. A base write with nothing pending has no effect on any output. If a base write coincides with a wrap, the strobe still fires and the new retrace stays pending.
- R9: frame_o increments by one, modulo 2^FRAME_W, in exactly the cycles in which present_o is high.
- R10: retrace_o, irq_a_o, irq_b_o and present_o are each high for single cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, one period = STEP_NS |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pal_sel_i | input | 1 | Standard select, sampled at frame wrap (1 = 625 lines) |
| cmp_wr_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 32 | Packed compare values: A in [25:16], B in [9:0] |
| base_wr_i | input | 1 | Display base-address write strobe |
| line_o | output | LINE_W | Current line number |
| frame_o | output | FRAME_W | Count of frame-present strobes |
| retrace_o | output | 1 | Retrace pulse on line wrap |
| irq_a_o | output | 1 | Scanline interrupt for compare A |
| irq_b_o | output | 1 | Scanline interrupt for compare B |
| present_o | output | 1 | Frame-present strobe |

## Verification
An advance, wrap, scanline interrupt or presentation-line strobe is decided on the clock edge at which the remainder crosses a line period. All of these results appear together with the new line_o value one cycle later. A base-address write produces its strobe one edge after the write is sampled. A compare write first affects the interrupts on the following edge. The bench advances a behavioural reference model on each rising edge, using the inputs that were driven at the previous falling edge. It compares every output against that model at the next falling edge, so each result is checked in exactly the cycle in which it is due.

// File: rtl/vt_pkg.sv
package vt_pkg;
    typedef enum logic {
        ST_SCAN    = 1'b0,
        ST_PENDING = 1'b1
    } vt_state_e;

    typedef struct packed {
        logic wrap;
        logic advance;
    } vt_line_evt_t;
endpackage

// File: rtl/vt_line_timer.sv
module vt_line_timer #(
    parameter int STEP_NS      = 10,
    parameter int NTSC_LINE_NS = 31746,
    parameter int PAL_LINE_NS  = 32000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pal_i,
    output logic tick_o
);
    localparam int MAX_NS = (PAL_LINE_NS > NTSC_LINE_NS) ? PAL_LINE_NS : NTSC_LINE_NS;
    localparam int ACC_W  = $clog2(MAX_NS + STEP_NS + 1);
    localparam logic [ACC_W-1:0] STEP = ACC_W'(STEP_NS);
    localparam logic [ACC_W-1:0] NTSC_P = ACC_W'(NTSC_LINE_NS);
    localparam logic [ACC_W-1:0] PAL_P  = ACC_W'(PAL_LINE_NS);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] period;

    always_comb begin
        sum    = acc_q + STEP;
        period = pal_i ? PAL_P : NTSC_P;
        tick_o = (sum >= period);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (tick_o) begin
            acc_q <= sum - period;
        end else begin
            acc_q <= sum;
        end
    end
endmodule

// File: rtl/vt_line_counter.sv
module vt_line_counter
    import vt_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              pal_i,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] line_next_o,
    output vt_line_evt_t      evt_o
);
    localparam logic [LINE_W-1:0] NTSC_T = LINE_W'(NTSC_LINES);
    localparam logic [LINE_W-1:0] PAL_T  = LINE_W'(PAL_LINES);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] inc;
    logic [LINE_W-1:0] total;

    always_comb begin
        inc           = line_q + LINE_W'(1);
        total         = pal_i ? PAL_T : NTSC_T;
        evt_o.advance = tick_i;
        evt_o.wrap    = tick_i && (inc == total);
        if (!tick_i) begin
            line_next_o = line_q;
        end else if (inc == total) begin
            line_next_o = '0;
        end else begin
            line_next_o = inc;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q <= '0;
        end else begin
            line_q <= line_next_o;
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/vt_cmp_unit.sv
module vt_cmp_unit #(
    parameter int LINE_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [LINE_W-1:0] wval_i,
    input  logic              adv_i,
    input  logic [LINE_W-1:0] line_next_i,
    output logic              hit_o
);
    logic [LINE_W-1:0] cmp_q;
    logic              hit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmp_q <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= adv_i && (line_next_i == cmp_q);
            if (wr_i) begin
                cmp_q <= wval_i;
            end
        end
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/vt_present_fsm.sv
module vt_present_fsm
    import vt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wrap_i,
    input  logic at_line_i,
    input  logic base_wr_i,
    output logic pending_o,
    output logic present_o
);
    vt_state_e state_q;
    vt_state_e state_d;
    logic      fire;
    logic      present_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fire    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_SCAN: begin
                if (wrap_i) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                fire = at_line_i || base_wr_i;
                if (wrap_i) begin
                    state_d = ST_PENDING;
                end else if (fire) begin
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            present_q <= 1'b0;
        end else begin
            present_q <= fire;
        end
    end

    assign pending_o = (state_q == ST_PENDING);
    assign present_o = present_q;
endmodule

// File: rtl/raster_vtiming.sv
module raster_vtiming
    import vt_pkg::*;
#(
    parameter int STEP_NS      = 10,
    parameter int NTSC_LINE_NS = 31746,
    parameter int PAL_LINE_NS  = 32000,
    parameter int NTSC_LINES   = 525,
    parameter int PAL_LINES    = 625,
    parameter int PRESENT_LINE = 65,
    parameter int LINE_W       = 10,
    parameter int FRAME_W      = 16,
    parameter int CMP_A_LSB    = 16,
    parameter int CMP_B_LSB    = 0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pal_sel_i,
    input  logic               cmp_wr_i,
    input  logic [31:0]        cmp_wdata_i,
    input  logic               base_wr_i,
    output logic [LINE_W-1:0]  line_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               retrace_o,
    output logic               irq_a_o,
    output logic               irq_b_o,
    output logic               present_o
);
    localparam int NCMP = 2;
    localparam logic [LINE_W-1:0] PRES_L = LINE_W'(PRESENT_LINE);

    logic              pal_q;
    logic              tick;
    logic [LINE_W-1:0] line_next;
    vt_line_evt_t      evt;
    logic              pending;
    logic              retrace_q;
    logic [FRAME_W-1:0] frame_q;
    logic [NCMP-1:0]   hits;
    logic              unused_wdata;

    assign unused_wdata = ^cmp_wdata_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pal_q <= 1'b0;
        end else if (evt.wrap) begin
            pal_q <= pal_sel_i;
        end
    end

    vt_line_timer #(
        .STEP_NS     (STEP_NS),
        .NTSC_LINE_NS(NTSC_LINE_NS),
        .PAL_LINE_NS (PAL_LINE_NS)
    ) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pal_i (pal_q),
        .tick_o(tick)
    );

    vt_line_counter #(
        .LINE_W    (LINE_W),
        .NTSC_LINES(NTSC_LINES),
        .PAL_LINES (PAL_LINES)
    ) u_lines (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .pal_i      (pal_q),
        .line_o     (line_o),
        .line_next_o(line_next),
        .evt_o      (evt)
    );

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        localparam int LSB = (k == 0) ? CMP_A_LSB : CMP_B_LSB;
        vt_cmp_unit #(
            .LINE_W(LINE_W)
        ) u_cmp (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .wr_i       (cmp_wr_i),
            .wval_i     (cmp_wdata_i[LSB +: LINE_W]),
            .adv_i      (evt.advance),
            .line_next_i(line_next),
            .hit_o      (hits[k])
        );
    end

    vt_present_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wrap_i   (evt.wrap),
        .at_line_i(evt.advance && (line_next == PRES_L)),
        .base_wr_i(base_wr_i),
        .pending_o(pending),
        .present_o(present_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            retrace_q <= 1'b0;
        end else begin
            retrace_q <= evt.wrap;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frame_q <= '0;
        end else if (u_fsm.state_q == ST_PENDING && u_fsm.fire) begin
            frame_q <= frame_q + FRAME_W'(1);
        end
    end

    assign frame_o   = frame_q;
    assign retrace_o = retrace_q;
    assign irq_a_o   = hits[0];
    assign irq_b_o   = hits[1];
endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
    parameter int LINE_W       = 10,
    parameter int FRAME_W      = 16,
    parameter int NTSC_LINES   = 525,
    parameter int PAL_LINES    = 625,
    parameter int PRESENT_LINE = 65
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               base_wr_i,
    input logic               pal_q,
    input logic               pending,
    input logic [LINE_W-1:0]  line_o,
    input logic [FRAME_W-1:0] frame_o,
    input logic               retrace_o,
    input logic               irq_a_o,
    input logic               irq_b_o,
    input logic               present_o
);
    p_line_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(line_o) < (pal_q ? PAL_LINES : NTSC_LINES));

    p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retrace_o |-> (line_o == '0) && pending);

    p_line_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_o != $past(line_o)) |-> ((line_o == $past(line_o) + LINE_W'(1)) || retrace_o));

    p_irq_needs_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_a_o || irq_b_o) |-> (line_o != $past(line_o)));

    p_present_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        present_o |-> $past(pending));

    p_present_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        present_o |-> ((int'(line_o) == PRESENT_LINE) || $past(base_wr_i)));

    p_frame_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        present_o |-> (frame_o == $past(frame_o) + FRAME_W'(1)));

    p_frame_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !present_o |-> $stable(frame_o));

    p_single_retrace_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retrace_o |=> !retrace_o);

    p_single_present_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        present_o |=> !present_o);
endmodule

bind raster_vtiming vt_checker #(
    .LINE_W      (LINE_W),
    .FRAME_W     (FRAME_W),
    .NTSC_LINES  (NTSC_LINES),
    .PAL_LINES   (PAL_LINES),
    .PRESENT_LINE(PRESENT_LINE)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_wr_i(base_wr_i),
    .pal_q    (pal_q),
    .pending  (pending),
    .line_o   (line_o),
    .frame_o  (frame_o),
    .retrace_o(retrace_o),
    .irq_a_o  (irq_a_o),
    .irq_b_o  (irq_b_o),
    .present_o(present_o)
);

// File: tb/raster_vtiming_tb.sv
module raster_vtiming_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP  = 3;
    localparam int N_NS  = 10;
    localparam int P_NS  = 11;
    localparam int N_TOT = 12;
    localparam int P_TOT = 15;
    localparam int PRES  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_sel = 1'b0;
    logic        cmp_wr = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic        base_wr = 1'b0;
    logic [9:0]  line;
    logic [15:0] frame;
    logic        retrace, irq_a, irq_b, present;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_rem, m_line, m_ca, m_cb, m_frame;
    bit m_pal, m_pend, e_ret, e_a, e_b, e_pres;
    int seen_a = 0, seen_b = 0, seen_base = 0, seen_wrap_pal = 0;

    raster_vtiming #(
        .STEP_NS(STEP), .NTSC_LINE_NS(N_NS), .PAL_LINE_NS(P_NS),
        .NTSC_LINES(N_TOT), .PAL_LINES(P_TOT), .PRESENT_LINE(PRES)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pal_sel_i(pal_sel),
        .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wdata), .base_wr_i(base_wr),
        .line_o(line), .frame_o(frame), .retrace_o(retrace),
        .irq_a_o(irq_a), .irq_b_o(irq_b), .present_o(present)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit hit, wrap;
        int per, tot;
        if (!rst_n) begin
            m_rem = 0; m_line = 0; m_ca = 0; m_cb = 0; m_frame = 0;
            m_pal = 0; m_pend = 0; e_ret = 0; e_a = 0; e_b = 0; e_pres = 0;
        end else begin
            e_ret = 0; e_a = 0; e_b = 0; e_pres = 0; wrap = 0;
            hit = base_wr && m_pend;
            if (hit) seen_base++;
            per = m_pal ? P_NS : N_NS;
            tot = m_pal ? P_TOT : N_TOT;
            m_rem += STEP;
            if (m_rem >= per) begin
                m_rem -= per;
                m_line++;
                if (m_line == tot) begin
                    m_line = 0; e_ret = 1; wrap = 1;
                end
                e_a = (m_line == m_ca);
                e_b = (m_line == m_cb);
                if (m_line == PRES && m_pend) e_pres = 1;
            end
            if (hit) e_pres = 1;
            if (e_pres) m_pend = 0;
            if (wrap) begin
                m_pend = 1;
                m_pal = pal_sel;
                if (pal_sel) seen_wrap_pal++;
            end
            if (cmp_wr) begin
                m_ca = int'(cmp_wdata[25:16]);
                m_cb = int'(cmp_wdata[9:0]);
            end
            if (e_pres) m_frame = (m_frame + 1) % 65536;
            if (e_a) seen_a++;
            if (e_b) seen_b++;
        end
    end

    // Compare on every falling edge, then drive the next inputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 R4 line", int'(line), m_line);
            check("R3 R10 retrace", int'(retrace), int'(e_ret));
            check("R5 R6 irq_a", int'(irq_a), int'(e_a));
            check("R5 R6 irq_b", int'(irq_b), int'(e_b));
            check("R7 R8 present", int'(present), int'(e_pres));
            check("R9 frame", int'(frame), m_frame);
        end
    end

    task automatic cycles(input int n, input int base_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_wr = 1'b0;
            base_wr = (base_every > 0) && ((i % base_every) == base_every - 1);
        end
    endtask

    task automatic write_cmp(input logic [31:0] w);
        @(negedge clk);
        base_wr = 1'b0;
        cmp_wr = 1'b1;
        cmp_wdata = w;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 line", int'(line), 0);
        check("R1 frame", int'(frame), 0);
        check("R1 pulses", int'({retrace, irq_a, irq_b, present}), 0);
        rst_n = 1'b1;
        // first cycle after reset: nothing has advanced yet
        @(negedge clk);
        // compare A = 5, B = 3, with set don't-care bits
        write_cmp(32'hFC05_FC03);
        cycles(200, 0);
        cycles(150, 17);
        pal_sel = 1'b1;
        write_cmp(32'h0000_000E);
        cycles(300, 7);
        write_cmp(32'h000B_0000);
        cycles(150, 3);
        pal_sel = 1'b0;
        cycles(200, 0);
        // base writes with nothing pending
        cycles(100, 2);
        check("R6 irq_a seen", int'(seen_a > 0), 1);
        check("R6 irq_b seen", int'(seen_b > 0), 1);
        check("R8 base strobe seen", int'(seen_base > 0), 1);
        check("R4 pal wrap seen", int'(seen_wrap_pal > 0), 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule